// File: doc/BRIEF.md
# Word-to-Bit Serializer with Divided Timing

The block turns 16-bit parallel words into a single bit stream that runs at the serial bit clock. One free-running phase counter, clocked by the bit clock, sets the whole schedule. It pulses a read request to an upstream FIFO, loads the word that the FIFO returns into a shift register, and drives a word-rate clock for the logic that produces the words. The FIFO is expected to present the requested word on the edge that follows the read request.

A feedback clock at the reference rate goes back to an external phase detector. When the feedback ratio equals the word width, the feedback clock comes from the same phase counter. Any other ratio builds its own divider. Two loopback paths support test. A select input replaces the transmitted stream with incoming receive data. A separate output always carries the serialized stream toward the receive side.

Top module: `word_serializer`

## Requirements
- R1: Each loaded word leaves on `tx_ser_o` most significant bit first, one bit per clock. Bit 15 is visible directly after the load edge and bit 0 fifteen clocks later.
- R2: A load takes `fifo_data_i` into the shift register on every 16th rising edge after reset is released. Counting the first edge with reset low as edge 1, loads happen at edges 16, 32, 48 and so on.
- R3: `fifo_rd_o` is high for exactly one clock in every 16. It is high after edges k with k mod 16 = 14, which is the cycle just before a load edge.
- R4: `word_clk_o` is the bit clock divided by 16. It is low after edges k with k mod 16 in 0..7 and high when k mod 16 is in 8..15.
- R5: A synchronous active-high reset clears the phase counter and the shift register, and drives all five outputs to 0. `tx_ser_o` stays 0 until the first load.
- R6: `fb_clk_o` repeats every FB_DIV clocks and is high while its phase is at least FB_DIV/2. This gives a 50% duty cycle for an even ratio. At the default ratio of 16 it matches `word_clk_o`.
- R7: When `line_lb_i` is 1 at an edge, `tx_ser_o` after that edge equals the value `rx_ser_i` had at that edge. The read and word-clock timing carry on unchanged while loopback is selected.
- R8: `diag_lb_o` carries the serialized bit at every clock, whatever the value of `line_lb_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_data_i | input | 16 | Word from the FIFO read port |
| fifo_rd_o | output | 1 | FIFO read request, one clock per word |
| rx_ser_i | input | 1 | Received serial data used for line loopback |
| line_lb_i | input | 1 | Selects received data onto the transmit output |
| tx_ser_o | output | 1 | Transmit serial data |
| diag_lb_o | output | 1 | Serialized data copied toward the receive side |
| word_clk_o | output | 1 | Word-rate clock for upstream logic |
| fb_clk_o | output | 1 | Feedback clock for the phase detector |

## Verification
Every output is a register, so each result appears one edge after the inputs that cause it. The only exception is the serial data, which depends on a word captured one edge before the load, so it arrives two edges after the read request. The bench keeps its own edge count from reset release and predicts read, word-clock and feedback levels from that count modulo 16. It predicts serial bits from the word loaded at the most recent multiple of 16. Inputs change on falling edges and outputs are sampled on the next falling edge, which falls between the edge that produces a result and the edge after it. For loopback, the expected bit is the receive value driven half a cycle before that edge.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic {
    SRC_SHIFT = 1'b0,
    SRC_LINE  = 1'b1
  } tx_src_e;
endpackage

// File: rtl/ser_timing.sv
module ser_timing #(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst,
  output logic load_o,
  output logic rd_o,
  output logic wclk_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int LAST  = WORD_W - 1;
  localparam int HALF  = WORD_W / 2;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic rd_q, wclk_q;

  always_comb begin
    if (cnt_q == CNT_W'(LAST)) cnt_nxt = '0;
    else                       cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      wclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      rd_q   <= (cnt_nxt == CNT_W'(LAST - 1));
      wclk_q <= (cnt_nxt >= CNT_W'(HALF));
    end
  end

  assign load_o = (cnt_q == CNT_W'(LAST));
  assign rd_o   = rd_q;
  assign wclk_o = wclk_q;

  // R3: the read request is a single clock wide and is followed by a load
  a_r3_rd_single: assert property (@(posedge clk) disable iff (rst)
    rd_q |=> !rd_q);
  a_r3_rd_then_load: assert property (@(posedge clk) disable iff (rst)
    rd_q |=> load_o);
  // R4: the word clock rises at mid-phase and falls at phase zero
  a_r4_wclk_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(wclk_q) |-> (cnt_q == CNT_W'(HALF)));
  a_r4_wclk_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(wclk_q) |-> (cnt_q == '0));
endmodule

// File: rtl/fb_div.sv
module fb_div #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic fb_o
);
  localparam int W    = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int LAST = DIV - 1;
  localparam int HALF = DIV / 2;

  logic [W-1:0] ph_q, ph_nxt;
  logic fb_q;

  always_comb begin
    if (ph_q == W'(LAST)) ph_nxt = '0;
    else                  ph_nxt = ph_q + W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
      fb_q <= 1'b0;
    end else begin
      ph_q <= ph_nxt;
      fb_q <= (ph_nxt >= W'(HALF));
    end
  end

  assign fb_o = fb_q;

  // R6: feedback edges sit at half phase and at phase zero
  a_r6_fb_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(fb_q) |-> (ph_q == W'(HALF)));
  a_r6_fb_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(fb_q) |-> (ph_q == '0));
endmodule

// File: rtl/ser_shift.sv
module ser_shift
  import ser_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              line_lb_i,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              diag_o
);
  logic [WORD_W-1:0] sr_q, sr_nxt;
  logic tx_q, diag_q;
  tx_src_e src;

  always_comb begin
    if (load_i) sr_nxt = data_i;
    else        sr_nxt = {sr_q[WORD_W-2:0], 1'b0};
    src = line_lb_i ? SRC_LINE : SRC_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      tx_q   <= 1'b0;
      diag_q <= 1'b0;
    end else begin
      sr_q   <= sr_nxt;
      diag_q <= sr_nxt[WORD_W-1];
      tx_q   <= (src == SRC_LINE) ? rx_i : sr_nxt[WORD_W-1];
    end
  end

  assign tx_o   = tx_q;
  assign diag_o = diag_q;

  // R1: the top bit leaves first, later bits follow in order
  a_r1_load_msb: assert property (@(posedge clk) disable iff (rst)
    (load_i && !line_lb_i) |=> (tx_q == $past(data_i[WORD_W-1])));
  a_r1_shift_order: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !line_lb_i) |=> (tx_q == $past(sr_q[WORD_W-2])));
  // R5: outputs are cleared by reset
  a_r5_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_q && !diag_q));
  // R7: line loopback passes the received bit through
  a_r7_line_pass: assert property (@(posedge clk) disable iff (rst)
    line_lb_i |=> (tx_q == $past(rx_i)));
  // R8: without loopback the diagnostic copy equals the transmit bit
  a_r8_diag_copy: assert property (@(posedge clk) disable iff (rst)
    !line_lb_i |=> (tx_q == diag_q));
endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int WORD_W = 16,
  parameter int FB_DIV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] fifo_data_i,
  output logic              fifo_rd_o,
  input  logic              rx_ser_i,
  input  logic              line_lb_i,
  output logic              tx_ser_o,
  output logic              diag_lb_o,
  output logic              word_clk_o,
  output logic              fb_clk_o
);
  logic load_w;
  logic wclk_w;

  ser_timing #(.WORD_W(WORD_W)) u_timing (
    .clk   (clk),
    .rst   (rst),
    .load_o(load_w),
    .rd_o  (fifo_rd_o),
    .wclk_o(wclk_w)
  );

  assign word_clk_o = wclk_w;

  generate
    if (FB_DIV == WORD_W) begin : g_fb_shared
      assign fb_clk_o = wclk_w;
    end else begin : g_fb_own
      fb_div #(.DIV(FB_DIV)) u_fb (
        .clk (clk),
        .rst (rst),
        .fb_o(fb_clk_o)
      );
    end
  endgenerate

  ser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_w),
    .data_i   (fifo_data_i),
    .line_lb_i(line_lb_i),
    .rx_i     (rx_ser_i),
    .tx_o     (tx_ser_o),
    .diag_o   (diag_lb_o)
  );

  // R2: the FIFO is asked for a word on the clock just before each load
  a_r2_load_after_rd: assert property (@(posedge clk) disable iff (rst)
    fifo_rd_o |=> load_w);
endmodule

// File: tb/sim_word_serializer.sv
module sim_word_serializer;
  logic clk = 1'b0;
  logic rst, line_lb, rx;
  logic [15:0] fdata;
  logic rd, tx, diag, wclk, fb;
  int k;
  int fidx;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // word[20:5], expected count of ones[4:0]
  localparam logic [20:0] VEC [8] = '{
    {16'hA5C3, 5'd8}, {16'h8001, 5'd2}, {16'hFFFF, 5'd16}, {16'h0000, 5'd0},
    {16'h1234, 5'd5}, {16'h7FFE, 5'd14}, {16'hC0DE, 5'd8}, {16'h0F0F, 5'd8}
  };

  always #2 clk = ~clk;

  word_serializer u0 (
    .clk(clk), .rst(rst), .fifo_data_i(fdata), .fifo_rd_o(rd),
    .rx_ser_i(rx), .line_lb_i(line_lb), .tx_ser_o(tx), .diag_lb_o(diag),
    .word_clk_o(wclk), .fb_clk_o(fb)
  );

  function automatic logic [15:0] word_of(int n);
    return (n < 8) ? VEC[n][20:5] : 16'hA5A5;
  endfunction

  function automatic logic exp_tx(int kk);
    logic [15:0] w;
    if (kk < 16) return 1'b0;
    w = word_of(kk / 16 - 1);
    return w[15 - (kk % 16)];
  endfunction

  always @(posedge clk) begin
    if (rst) k <= 0;
    else     k <= k + 1;
  end

  always @(posedge clk) begin
    if (rst) begin
      fidx  <= 0;
      fdata <= 16'h0000;
    end else if (rd) begin
      fdata <= word_of(fidx);
      fidx  <= fidx + 1;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %b expected %b", req, k, act, exp);
    end
  endtask

  task automatic chk_timing(string req);
    chk({req, " rd"}, rd, (k % 16) == 14);
    chk({req, " word clk"}, wclk, (k % 16) >= 8);
    chk({req, " fb clk"}, fb, (k % 16) >= 8);
  endtask

  task automatic chk_reset_state();
    chk("R5 tx", tx, 1'b0);
    chk("R5 rd", rd, 1'b0);
    chk("R5 word clk", wclk, 1'b0);
    chk("R5 fb clk", fb, 1'b0);
    chk("R5 diag", diag, 1'b0);
  endtask

  initial begin
    int ones;
    rst = 1'b1; line_lb = 1'b0; rx = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_reset_state();
    rst = 1'b0;
    // before the first load: output held at 0, timing running (R3 R4 R6)
    for (int c = 1; c < 16; c++) begin
      @(negedge clk);
      chk("R5 idle tx", tx, 1'b0);
      chk_timing("R3/R4/R6");
    end
    // vector table walk: R1 order, R2 word capture, R8 diag copy
    for (int n = 0; n < 8; n++) begin
      ones = 0;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        chk("R1 serial bit", tx, VEC[n][20 - i]);
        chk("R8 diag", diag, VEC[n][20 - i]);
        chk_timing("R4");
        if (tx === 1'b1) ones++;
      end
      checks++;
      if (ones != int'(VEC[n][4:0])) begin
        errors++;
        $display("FAIL R2 word %0d ones: actual %0d expected %0d", n, ones, VEC[n][4:0]);
      end
    end
    // line loopback (R7), diag keeps serial data (R8)
    line_lb = 1'b1;
    for (int j = 0; j < 32; j++) begin
      logic b;
      b = ((j * 7) % 3) == 0;
      rx = b;
      @(negedge clk);
      chk("R7 loopback tx", tx, b);
      chk("R8 diag under loopback", diag, exp_tx(k));
      chk_timing("R7");
    end
    line_lb = 1'b0;
    rx = 1'b1;
    @(negedge clk);
    chk("R7 back to serial", tx, exp_tx(k));
    // mid-stream reset (R5) then restart (R2 R3)
    rst = 1'b1;
    @(negedge clk);
    chk_reset_state();
    @(negedge clk);
    rst = 1'b0;
    for (int c = 1; c < 36; c++) begin
      @(negedge clk);
      chk("R2 restart tx", tx, exp_tx(k));
      chk_timing("R3 restart");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule